// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a parallel NOR flash bus. It runs the whole write algorithm for one of three jobs: program one word (or byte), erase one sector, or erase the entire array. After a job is accepted, the block drives the unlock and command write cycles on the flash bus. It then polls the device with read cycles until the device reports that the job is complete, or until the job is judged to have failed. A last read checks the stored value. The result comes back as a one-cycle done pulse that carries a pass or fail flag.

Two ways of detecting completion are supported. In data-polling mode the block compares status bit 7 of each read with the value that is expected at the end. In toggle mode it compares status bit 6 across two reads in a row. A configuration input selects the mode. A second input selects byte-wide or word-wide addressing of the unlock locations. Both inputs are sampled when a job is accepted. Write strobe widths, read widths, the gap between polls and a polling watchdog are all parameters counted in clock cycles.

The top-level machine has these states. IDLE accepts a job. CMD issues the command writes one after another. POLL1 and POLL2 hold the first and second status read of a poll. RCHK1 and RCHK2 are the one or two confirming reads made once the time-limit flag is seen. VERIFY is the final read-back. ABORT writes the reset command. DONE presents the result. The transitions are:
- IDLE→CMD on an accepted request.
- CMD→POLL1 after the last command write.
- In data-polling mode, POLL1 goes to VERIFY, POLL1, RCHK1 or ABORT.
- In toggle mode, POLL1→POLL2, and POLL2 goes to VERIFY, POLL1, RCHK1 or ABORT.
- RCHK1 goes to VERIFY or ABORT in data-polling mode, and to RCHK2 in toggle mode.
- RCHK2 goes to VERIFY or ABORT.
- VERIFY goes to DONE or ABORT.
- ABORT→DONE.
- DONE→IDLE.

Top module: `flash_op_ctrl`

## Requirements
- R1: A program job (req_op 0) issues exactly these writes, in this order, before any read: U1/AAh, U2/55h, U1/A0h, then the target address with the target data.
- R2: A sector erase job (req_op 1) issues U1/AAh, U2/55h, U1/80h, U1/AAh, U2/55h, then the target address with 30h. A chip erase job (req_op 2 or 3) issues the same five writes and ends with U1/10h. Command values occupy data bits 7:0, and the upper data bits are zero.
- R3: In word mode (cfg_byte 0) U1 is 555h and U2 is 2AAh. In byte mode (cfg_byte 1) U1 is AAAh and U2 is 555h. In byte mode only data bits 7:0 of the program value are written.
- R4: In data-polling mode (cfg_toggle 0) every status read is taken at the target address. When bit 7 equals the expected bit (bit 7 of the program value, or 1 for either erase), polling ends with success. Otherwise polling goes on while bit 5 is 0.
- R5: In toggle mode (cfg_toggle 1) status reads come in pairs. Polling ends with success when bit 6 is the same in both reads. Otherwise it goes on while bit 5 of the second read is 0.
- R6: When bit 5 is seen as 1 while the device is still busy, the block makes one more read (data-polling) or one more pair of reads (toggle). The job fails unless that confirming read shows completion by the same rule.
- R7: After the polling phase succeeds, one more read at the target address must return the program value (byte mode: bits 7:0 only) or all ones (byte mode: FFh) for an erase. If it does not, the job fails.
- R8: A failed job ends with one extra write of F0h, and only then is done raised with done_ok 0.
- R9: If the polling phase lasts more than P_WDOG clock cycles without success, the job fails.
- R10: Every write keeps fl_we_n low for exactly P_WE_LOW cycles, with address and data stable. fl_we_n and fl_oe_n are never low together, and neither is low while fl_ce_n is high.
- R11: req_ack is high, in the same cycle, only while the block is idle and req_valid is high. Requests made while a job runs are not acknowledged. done is a one-cycle pulse per accepted job.
- R12: After reset, fl_ce_n, fl_we_n and fl_oe_n are high and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_toggle | input | 1 | 1 selects toggle-bit completion detection |
| cfg_byte | input | 1 | 1 selects byte-mode unlock addresses and 8-bit data |
| req_valid | input | 1 | Job request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 or 3 chip erase |
| req_addr | input | AW | Target address (a location inside the sector for erase jobs) |
| req_data | input | DW | Program value |
| req_ack | output | 1 | Request accepted this cycle |
| done | output | 1 | Job finished (one-cycle pulse) |
| done_ok | output | 1 | Job passed, valid with done |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data |
| fl_ce_n | output | 1 | Flash chip enable, low while a job runs |
| fl_we_n | output | 1 | Flash write strobe |
| fl_oe_n | output | 1 | Flash output enable |

## Verification
The assertions check the bus-cycle rules on every cycle. These cover the write strobe width, stable address and data while the strobe is low, exclusive strobes gated by chip enable, and the single acknowledge and done per job. They also check that no failure is reported without a preceding F0h write. Only the bench's scenarios with a device model can show that the algorithm reaches the right verdict. Those scenarios are: normal completion after a random busy time, late completion caught by the confirming read, a flag that never clears, a device that never finishes, and a wrong final value, each in both detection modes. The same scenarios compare the exact command write sequences for each job and address mode.

// File: rtl/flash_op_pkg.sv
package flash_op_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        VD_PASS  = 2'd0,
        VD_WAIT  = 2'd1,
        VD_RECHK = 2'd2,
        VD_FAIL  = 2'd3
    } verdict_e;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_ERASE_SU = 8'h80;
    localparam logic [7:0] CMD_CHIP_GO  = 8'h10;
    localparam logic [7:0] CMD_SECT_GO  = 8'h30;
    localparam logic [7:0] CMD_RESET    = 8'hF0;

    localparam logic [11:0] UA_WORD_1 = 12'h555;
    localparam logic [11:0] UA_WORD_2 = 12'h2AA;
    localparam logic [11:0] UA_BYTE_1 = 12'hAAA;
    localparam logic [11:0] UA_BYTE_2 = 12'h555;

    localparam int BIT_DONE   = 7;
    localparam int BIT_TOGGLE = 6;
    localparam int BIT_LIMIT  = 5;

endpackage

// File: rtl/flash_bus_cycler.sv
module flash_bus_cycler #(
    parameter int AW        = 21,
    parameter int DW        = 16,
    parameter int P_WE_LOW  = 3,
    parameter int P_WE_HIGH = 2,
    parameter int P_RD_ACT  = 2,
    parameter int P_RD_GAP  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    output logic          cyc_done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          we_n,
    output logic          oe_n
);
    localparam int MAX_A = (P_WE_LOW > P_WE_HIGH) ? P_WE_LOW : P_WE_HIGH;
    localparam int MAX_B = (P_RD_ACT > P_RD_GAP) ? P_RD_ACT : P_RD_GAP;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_C + 1);

    typedef enum logic [2:0] {C_IDLE, C_WLOW, C_WHIGH, C_RACT, C_RGAP} cyc_st_e;

    cyc_st_e       cst;
    logic [CW-1:0] cnt;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cst     <= C_IDLE;
            cnt     <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            last_q  <= 1'b0;
        end else begin
            last_q <= 1'b0;
            unique case (cst)
                C_IDLE: begin
                    if (start) begin
                        addr_q  <= addr_in;
                        wdata_q <= wdata_in;
                        if (wr) begin
                            cst <= C_WLOW;
                            cnt <= CW'(P_WE_LOW - 1);
                        end else begin
                            cst <= C_RACT;
                            cnt <= CW'(P_RD_ACT - 1);
                        end
                    end
                end
                C_WLOW: begin
                    if (cnt == '0) begin
                        cst <= C_WHIGH;
                        cnt <= CW'(P_WE_HIGH - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                C_WHIGH: begin
                    if (cnt == '0) begin
                        cst    <= C_IDLE;
                        last_q <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                C_RACT: begin
                    if (cnt == '0) begin
                        rdata_q <= bus_rdata;
                        cst     <= C_RGAP;
                        cnt     <= CW'(P_RD_GAP - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                C_RGAP: begin
                    if (cnt == '0) begin
                        cst    <= C_IDLE;
                        last_q <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: cst <= C_IDLE;
            endcase
        end
    end

    always_comb begin
        we_n      = (cst != C_WLOW);
        oe_n      = (cst != C_RACT);
        bus_addr  = addr_q;
        bus_wdata = wdata_q;
        rdata     = rdata_q;
        cyc_done  = last_q;
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_op_pkg::*;
#(
    parameter int AW = 21,
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic [2:0]    idx,
    input  logic          byte_mode,
    input  logic          abort,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] tgt_data,
    output logic [AW-1:0] seq_addr,
    output logic [DW-1:0] seq_data,
    output logic          seq_last
);
    logic [AW-1:0] ua1, ua2;
    logic [7:0]    cmd;
    logic          use_tgt_addr;
    logic          use_tgt_data;

    always_comb begin
        ua1 = AW'(byte_mode ? UA_BYTE_1 : UA_WORD_1);
        ua2 = AW'(byte_mode ? UA_BYTE_2 : UA_WORD_2);
        cmd          = CMD_RESET;
        use_tgt_addr = 1'b0;
        use_tgt_data = 1'b0;
        seq_last     = 1'b0;
        seq_addr     = ua1;
        if (abort) begin
            seq_addr = '0;
            cmd      = CMD_RESET;
            seq_last = 1'b1;
        end else if (op == OP_PROG) begin
            unique case (idx)
                3'd0:    begin seq_addr = ua1; cmd = CMD_UNLOCK_A; end
                3'd1:    begin seq_addr = ua2; cmd = CMD_UNLOCK_B; end
                3'd2:    begin seq_addr = ua1; cmd = CMD_PROGRAM;  end
                default: begin
                    use_tgt_addr = 1'b1;
                    use_tgt_data = 1'b1;
                    seq_last     = 1'b1;
                end
            endcase
        end else begin
            unique case (idx)
                3'd0:    begin seq_addr = ua1; cmd = CMD_UNLOCK_A; end
                3'd1:    begin seq_addr = ua2; cmd = CMD_UNLOCK_B; end
                3'd2:    begin seq_addr = ua1; cmd = CMD_ERASE_SU; end
                3'd3:    begin seq_addr = ua1; cmd = CMD_UNLOCK_A; end
                3'd4:    begin seq_addr = ua2; cmd = CMD_UNLOCK_B; end
                default: begin
                    seq_last = 1'b1;
                    if (op == OP_SECT) begin
                        use_tgt_addr = 1'b1;
                        cmd          = CMD_SECT_GO;
                    end else begin
                        seq_addr = ua1;
                        cmd      = CMD_CHIP_GO;
                    end
                end
            endcase
        end
        if (use_tgt_addr) seq_addr = tgt_addr;
        seq_data = use_tgt_data ? tgt_data : DW'(cmd);
    end

endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge
    import flash_op_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          toggle_mode,
    input  logic          recheck,
    input  logic          exp_bit,
    input  logic [DW-1:0] prev_rd,
    input  logic [DW-1:0] cur_rd,
    output verdict_e      verdict
);
    logic complete;

    always_comb begin
        if (toggle_mode) complete = (prev_rd[BIT_TOGGLE] == cur_rd[BIT_TOGGLE]);
        else             complete = (cur_rd[BIT_DONE] == exp_bit);

        if (complete)                verdict = VD_PASS;
        else if (recheck)            verdict = VD_FAIL;
        else if (cur_rd[BIT_LIMIT])  verdict = VD_RECHK;
        else                         verdict = VD_WAIT;
    end

endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
    import flash_op_pkg::*;
#(
    parameter int AW        = 21,
    parameter int DW        = 16,
    parameter int P_WE_LOW  = 3,
    parameter int P_WE_HIGH = 2,
    parameter int P_RD_ACT  = 2,
    parameter int P_RD_GAP  = 2,
    parameter int P_WDOG    = 100000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_toggle,
    input  logic          cfg_byte,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          req_ack,
    output logic          done,
    output logic          done_ok,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic [DW-1:0] fl_rdata,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int WDW = $clog2(P_WDOG + 2);
    localparam logic [DW-1:0] BYTE_MASK = DW'(8'hFF);

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_POLL1, S_POLL2, S_RCHK1, S_RCHK2, S_VERIFY, S_ABORT, S_DONE
    } st_e;

    st_e            state, nxt;
    op_e            op_q;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  data_q;
    logic           tog_q, byte_q, ok_q, launched_q;
    logic [2:0]     idx_q;
    logic [DW-1:0]  prev_q;
    logic [WDW-1:0] wd_q;

    logic           cyc_start, cyc_wr, cyc_done;
    logic [AW-1:0]  cyc_addr;
    logic [DW-1:0]  cyc_wdata, cyc_rdata;
    logic [AW-1:0]  seq_addr;
    logic [DW-1:0]  seq_data;
    logic           seq_last;
    verdict_e       verdict;
    logic           bus_state, rechk_state, wd_expired;
    logic           exp7;
    logic [DW-1:0]  exp_final, rd_masked;
    op_e            req_op_dec;

    assign req_op_dec = (req_op == 2'd0) ? OP_PROG : (req_op == 2'd1) ? OP_SECT : OP_CHIP;
    assign exp7       = (op_q == OP_PROG) ? data_q[BIT_DONE] : 1'b1;
    assign exp_final  = (op_q == OP_PROG) ? data_q : (byte_q ? BYTE_MASK : '1);
    assign rd_masked  = byte_q ? (cyc_rdata & BYTE_MASK) : cyc_rdata;
    assign wd_expired = (wd_q > WDW'(P_WDOG));
    assign rechk_state = (state == S_RCHK1) || (state == S_RCHK2);

    flash_cmd_seq #(.AW(AW), .DW(DW)) seq_i (
        .op        (op_q),
        .idx       (idx_q),
        .byte_mode (byte_q),
        .abort     (state == S_ABORT),
        .tgt_addr  (addr_q),
        .tgt_data  (data_q),
        .seq_addr  (seq_addr),
        .seq_data  (seq_data),
        .seq_last  (seq_last)
    );

    flash_poll_judge #(.DW(DW)) judge_i (
        .toggle_mode (tog_q),
        .recheck     (rechk_state),
        .exp_bit     (exp7),
        .prev_rd     (prev_q),
        .cur_rd      (cyc_rdata),
        .verdict     (verdict)
    );

    flash_bus_cycler #(
        .AW(AW), .DW(DW), .P_WE_LOW(P_WE_LOW), .P_WE_HIGH(P_WE_HIGH),
        .P_RD_ACT(P_RD_ACT), .P_RD_GAP(P_RD_GAP)
    ) cyc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cyc_start),
        .wr        (cyc_wr),
        .addr_in   (cyc_addr),
        .wdata_in  (cyc_wdata),
        .cyc_done  (cyc_done),
        .rdata     (cyc_rdata),
        .bus_addr  (fl_addr),
        .bus_wdata (fl_wdata),
        .bus_rdata (fl_rdata),
        .we_n      (fl_we_n),
        .oe_n      (fl_oe_n)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (req_ack) nxt = S_CMD;
            S_CMD:   if (cyc_done && seq_last) nxt = S_POLL1;
            S_POLL1, S_POLL2: begin
                if (cyc_done) begin
                    if (tog_q && state == S_POLL1) begin
                        nxt = S_POLL2;
                    end else begin
                        unique case (verdict)
                            VD_PASS:  nxt = S_VERIFY;
                            VD_RECHK: nxt = S_RCHK1;
                            VD_WAIT:  nxt = wd_expired ? S_ABORT : S_POLL1;
                            default:  nxt = S_ABORT;
                        endcase
                    end
                end
            end
            S_RCHK1, S_RCHK2: begin
                if (cyc_done) begin
                    if (tog_q && state == S_RCHK1) nxt = S_RCHK2;
                    else nxt = (verdict == VD_PASS) ? S_VERIFY : S_ABORT;
                end
            end
            S_VERIFY: if (cyc_done) nxt = (rd_masked == exp_final) ? S_DONE : S_ABORT;
            S_ABORT:  if (cyc_done) nxt = S_DONE;
            S_DONE:   nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // job context and polling bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_PROG;
            addr_q     <= '0;
            data_q     <= '0;
            tog_q      <= 1'b0;
            byte_q     <= 1'b0;
            ok_q       <= 1'b0;
            launched_q <= 1'b0;
            idx_q      <= '0;
            prev_q     <= '0;
            wd_q       <= '0;
        end else begin
            if (req_ack) begin
                op_q   <= req_op_dec;
                addr_q <= req_addr;
                data_q <= cfg_byte ? (req_data & BYTE_MASK) : req_data;
                tog_q  <= cfg_toggle;
                byte_q <= cfg_byte;
                ok_q   <= 1'b0;
                idx_q  <= '0;
            end
            if (cyc_start)     launched_q <= 1'b1;
            else if (cyc_done) launched_q <= 1'b0;
            if (cyc_done) begin
                prev_q <= cyc_rdata;
                if (state == S_CMD) idx_q <= idx_q + 1'b1;
            end
            if (state == S_CMD) wd_q <= '0;
            else if (!wd_expired) wd_q <= wd_q + 1'b1;
            if (state == S_VERIFY && nxt == S_DONE) ok_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        bus_state = (state != S_IDLE) && (state != S_DONE);
        cyc_start = bus_state && !launched_q;
        cyc_wr    = (state == S_CMD) || (state == S_ABORT);
        cyc_addr  = cyc_wr ? seq_addr : addr_q;
        cyc_wdata = cyc_wr ? seq_data : '0;
        fl_ce_n   = !bus_state;
        req_ack   = (state == S_IDLE) && req_valid;
        done      = (state == S_DONE);
        done_ok   = (state == S_DONE) && ok_q;
    end

endmodule

// File: rtl/flash_op_ctrl_chk.sv
module flash_op_ctrl_chk #(
    parameter int AW       = 21,
    parameter int DW       = 16,
    parameter int P_WE_LOW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ack,
    input logic          done,
    input logic          done_ok,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_wdata,
    input logic          fl_ce_n,
    input logic          fl_we_n,
    input logic          fl_oe_n
);
    localparam int LW = $clog2(P_WE_LOW + 2) + 1;

    logic [LW-1:0] lo_cnt;
    logic          op_open, saw_reset, we_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt    <= '0;
            op_open   <= 1'b0;
            saw_reset <= 1'b0;
            we_prev   <= 1'b1;
        end else begin
            we_prev <= fl_we_n;
            if (!fl_we_n) lo_cnt <= lo_cnt + 1'b1;
            else          lo_cnt <= '0;
            if (req_ack)   op_open <= 1'b1;
            else if (done) op_open <= 1'b0;
            if (req_ack) saw_reset <= 1'b0;
            else if (!we_prev && fl_we_n && fl_wdata[7:0] == 8'hF0) saw_reset <= 1'b1;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n)); // R10
    AST_STROBE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !fl_oe_n) |-> !fl_ce_n); // R10
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (lo_cnt == LW'(P_WE_LOW))); // R10
    AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && !we_prev) |-> ($stable(fl_addr) && $stable(fl_wdata))); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> !op_open); // R11
    AST_DONE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> op_open); // R11
    AST_FAIL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ok) |-> saw_reset); // R8

endmodule

bind flash_op_ctrl flash_op_ctrl_chk #(.AW(AW), .DW(DW), .P_WE_LOW(P_WE_LOW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ack  (req_ack),
    .done     (done),
    .done_ok  (done_ok),
    .fl_addr  (fl_addr),
    .fl_wdata (fl_wdata),
    .fl_ce_n  (fl_ce_n),
    .fl_we_n  (fl_we_n),
    .fl_oe_n  (fl_oe_n)
);

// File: tb/flash_op_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_op_ctrl_tb_top;
    localparam int AW = 21;
    localparam int DW = 16;
    localparam int WEL = 3;
    localparam int WDOG = 600;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_toggle = 1'b0, cfg_byte = 1'b0, req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_ack, done, done_ok;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata;
    logic [DW-1:0] fl_rdata = '0;
    logic          fl_ce_n, fl_we_n, fl_oe_n;

    always #5 clk = ~clk;

    flash_op_ctrl #(.AW(AW), .DW(DW), .P_WE_LOW(WEL), .P_WE_HIGH(2),
                    .P_RD_ACT(2), .P_RD_GAP(2), .P_WDOG(WDOG)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_toggle(cfg_toggle), .cfg_byte(cfg_byte),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .req_ack(req_ack), .done(done), .done_ok(done_ok),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

    int n_chk = 0, n_err = 0;
    bit finished = 0;
    int unsigned cyc = 0;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // expected write list
    logic [AW-1:0] exp_a [0:7];
    logic [DW-1:0] exp_d [0:7];
    int            exp_n, seq_n;
    string         wtag;

    task automatic build_exp(input int op, input bit byt, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input bit fails);
        logic [AW-1:0] u1, u2;
        u1 = byt ? AW'(12'hAAA) : AW'(12'h555);
        u2 = byt ? AW'(12'h555) : AW'(12'h2AA);
        exp_a[0] = u1; exp_d[0] = 16'hAA;
        exp_a[1] = u2; exp_d[1] = 16'h55;
        if (op == 0) begin
            exp_a[2] = u1; exp_d[2] = 16'hA0;
            exp_a[3] = a;  exp_d[3] = byt ? (d & 16'hFF) : d;
            seq_n = 4;
        end else begin
            exp_a[2] = u1; exp_d[2] = 16'h80;
            exp_a[3] = u1; exp_d[3] = 16'hAA;
            exp_a[4] = u2; exp_d[4] = 16'h55;
            if (op == 1) begin exp_a[5] = a;  exp_d[5] = 16'h30; end
            else         begin exp_a[5] = u1; exp_d[5] = 16'h10; end
            seq_n = 6;
        end
        exp_n = seq_n;
        if (fails) begin
            exp_a[seq_n] = '0; exp_d[seq_n] = 16'hF0;
            exp_n = seq_n + 1;
        end
    endtask

    // device model
    bit            trk = 0;
    int            w_cnt = 0;
    bit            m_busy = 0, m_forever = 0, m_dq5 = 0, m_exp7 = 0, m_tog = 0;
    int            m_left = 0;
    logic [DW-1:0] m_final = '0;
    int unsigned   lo_start = 0;

    always @(negedge fl_we_n) if (trk) lo_start = cyc;

    always @(posedge fl_we_n) begin
        if (trk) begin
            chk(cyc - lo_start == WEL, "R10", cyc - lo_start, WEL);
            if (w_cnt < exp_n) begin
                if (w_cnt >= seq_n) begin
                    chk(fl_addr == exp_a[w_cnt] && fl_wdata == exp_d[w_cnt], "R8",
                        {fl_addr[15:0], fl_wdata}, {exp_a[w_cnt][15:0], exp_d[w_cnt]});
                    m_busy = 0;
                end else begin
                    chk(fl_addr == exp_a[w_cnt] && fl_wdata == exp_d[w_cnt], wtag,
                        {fl_addr[15:0], fl_wdata}, {exp_a[w_cnt][15:0], exp_d[w_cnt]});
                    if (w_cnt == seq_n - 1) m_busy = 1;
                end
            end else begin
                chk(0, "R8", w_cnt, exp_n);
            end
            w_cnt++;
        end
    end

    always @(negedge fl_oe_n) begin
        if (trk) begin
            if (m_busy && (m_forever || m_left > 0)) begin
                fl_rdata = '0;
                fl_rdata[7] = ~m_exp7;
                fl_rdata[6] = m_tog;
                fl_rdata[5] = m_dq5;
                m_tog = ~m_tog;
                if (!m_forever) m_left--;
            end else begin
                m_busy = 0;
                fl_rdata = m_final;
            end
        end
    end

    // scenario: 0 normal, 1 late finish after limit flag, 2 flag stuck, 3 hang, 4 bad value
    task automatic run_op(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit tog, input bit byt, input int scen);
        bit fails;
        logic [DW-1:0] fin;
        string rtag;
        int n;
        fails = (scen >= 2);
        fin = (op == 0) ? (byt ? (d & 16'hFF) : d) : (byt ? 16'hFF : 16'hFFFF);
        build_exp(op, byt, a, d, fails);
        wtag = byt ? "R3" : ((op == 0) ? "R1" : "R2");
        rtag = (scen == 0) ? (tog ? "R5" : "R4") : (scen == 3) ? "R9" : (scen == 4) ? "R7" : "R6";
        w_cnt = 0; m_busy = 0; m_tog = 0;
        m_forever = (scen == 2 || scen == 3);
        m_dq5 = (scen == 1 || scen == 2);
        m_left = (scen == 1) ? (tog ? 2 : 1) : int'($urandom % 12);
        m_final = fin ^ ((scen == 4) ? 16'h1 : 16'h0);
        m_exp7 = (op == 0) ? d[7] : 1'b1;
        trk = 1;
        @(negedge clk);
        cfg_toggle = tog; cfg_byte = byt;
        req_valid = 1; req_op = (op == 2) ? (($urandom % 2) ? 2'd3 : 2'd2) : 2'(op);
        req_addr = a; req_data = d;
        #1 chk(req_ack == 1, "R11", req_ack, 1);
        @(negedge clk);
        req_op = ~req_op; req_data = ~d;
        for (int k = 0; k < 3; k++) begin
            #1 chk(req_ack == 0, "R11", req_ack, 0);
            @(negedge clk);
        end
        req_valid = 0;
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk(done == 1, rtag, done, 1);
        chk(done_ok == !fails, rtag, done_ok, !fails);
        chk(w_cnt == exp_n, "R8", w_cnt, exp_n);
        @(negedge clk);
        chk(done == 0, "R11", done, 0);
        trk = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'h1F2E3D);
        repeat (3) @(negedge clk);
        chk(fl_ce_n && fl_we_n && fl_oe_n && !done, "R12", {fl_ce_n, fl_we_n, fl_oe_n, done}, 4'hE);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(fl_ce_n && fl_we_n && fl_oe_n && !done, "R12", {fl_ce_n, fl_we_n, fl_oe_n, done}, 4'hE);
        for (int i = 0; i < 30; i++)
            run_op((i / 10) % 3, AW'($urandom), DW'($urandom), ((i / 5) % 2) == 1, (i % 2) == 1, i % 5);
        for (int i = 0; i < 30; i++)
            run_op(int'($urandom % 3), AW'($urandom), DW'($urandom), $urandom % 2 == 1,
                   $urandom % 2 == 1, int'($urandom % 5));
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule